// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmit Framer

This block turns bytes into asynchronous serial frames. An 8-bit line-control register sets the frame shape: 5 to 8 data bits, optional parity (even, odd, or forced to a constant), and one or two stop bits. The same register chooses between a 16-entry transmit queue and a single-byte holding register. A small register write port loads the line-control register and two baud divisor values. The two divisor values are held in shadow copies and reach the outputs that feed the external baud-rate counter only when the line-control register is written.

The block does not generate its own bit timing. It counts a 16x oversampling enable pulse, `tick16`, supplied by the external divisor counter, so every serial bit lasts 16 of those pulses. The frame format is captured at the moment a frame starts. A register write made while a frame is on the line therefore changes only the frames that follow.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset `tx` is 1, `busy` and `full` are 0, and the line-control register and both active and shadow divisors are 0.
- R2: A write to address 0 stores `wr_data[7:0]` as the line-control byte. Reading address 0 returns that byte in `rd_data[7:0]`, and `rd_data[31:8]` reads 0 whatever was written. The bit map is: bit 1 parity on, bit 2 even select, bit 3 two stop bits, bit 4 queue mode, bits 6:5 length code, bit 7 forced parity. Bit 0 is stored only.
- R3: A frame is one low start bit, then the data bits LSB first, then an optional parity bit, then the high stop bit(s). Each bit lasts exactly 16 `tick16` pulses. Length code 0/1/2/3 selects 5/6/7/8 data bits, and unused upper data bits are not sent.
- R4: With parity on and forced parity off, the parity bit makes the count of ones over data and parity even when bit 2 is set, and odd when bit 2 is clear.
- R5: With parity on and forced parity on, the parity bit is 0 when bit 2 is set and 1 when bit 2 is clear, whatever the data.
- R6: With bit 3 set the frame ends with two stop bits (32 ticks high); otherwise it ends with one.
- R7: Writes to address 1 (integer divisor, 16 bits) and address 2 (fractional divisor, 6 bits) change only the shadow copies, which read back at those addresses. `div_int` and `div_frac` take the shadow values on the clock edge of the next write to address 0, and at no other time.
- R8: The frame format is sampled when a frame starts. A line-control write during a frame leaves that frame's length and bits unchanged, and the next frame uses the new format.
- R9: With bit 4 clear, the transmit buffer holds one byte. `full` is 1 while that byte waits, and a push while `full` is dropped.
- R10: With bit 4 set, up to 16 waiting bytes are queued and sent in push order. `full` is 1 at 16 waiting bytes, a push while full is dropped, and `full` stays 1.
- R11: `busy` is 1 while a byte waits or a frame is on the line. It falls in the cycle after the 16th tick of the last stop bit when nothing else waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 line control, 1 integer divisor, 2 fractional divisor |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data for `reg_addr` (line control or shadow divisor) |
| push_valid | input | 1 | Push one byte into the transmit buffer |
| push_data | input | 8 | Byte to send |
| tick16 | input | 1 | 16x baud enable pulse from the divisor counter |
| tx | output | 1 | Serial output, idle high |
| busy | output | 1 | A byte waits or a frame is being sent |
| full | output | 1 | Transmit buffer cannot accept a push |
| div_int | output | 16 | Active integer baud divisor |
| div_frac | output | 6 | Active fractional baud divisor |

## Verification
A wrong frame length or parity choice corrupts the line within one bit time: a misplaced stop or parity bit shows 16 ticks early or late, and a mid-bit sample catches it at once. A buffer count that is off shows at `full` in the cycle after the push, and the extra or lost byte shows one frame later as an extra frame, a missing frame, or bytes out of order. A divisor taken from the shadow at the wrong time shows on `div_int` or `div_frac` in the cycle after the write.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Line-control byte, bit 7 down to bit 0
  typedef struct packed {
    logic       stick;
    logic [1:0] wlen;
    logic       q_en;
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       spare;
  } lcr_t;

  localparam int FRAME_MAX = 12;

  // Total bits in a frame: start + data + parity + stops
  function automatic logic [3:0] frame_len(lcr_t c);
    return 4'd6 + {2'b00, c.wlen} + {3'b000, c.par_en} + (c.two_stop ? 4'd2 : 4'd1);
  endfunction

  function automatic logic parity_of(logic [7:0] d, lcr_t c);
    logic [7:0] m;
    m = d & (8'hFF >> (2'd3 - c.wlen));
    if (c.stick) return ~c.even;
    return c.even ? ^m : ~^m;
  endfunction

  // Bit 0 goes out first; positions past the frame stay high
  function automatic logic [FRAME_MAX-1:0] build_frame(logic [7:0] d, lcr_t c);
    logic [FRAME_MAX-1:0] f;
    int nd;
    f = '1;
    f[0] = 1'b0;
    nd = 5 + int'(c.wlen);
    for (int i = 0; i < 8; i++)
      if (i < nd) f[1+i] = d[i];
    if (c.par_en) f[1+nd] = parity_of(d, c);
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DIVI_W = 16,
  parameter int DIVF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output lcr_t              lcr,
  output logic [DIVI_W-1:0] div_int,
  output logic [DIVF_W-1:0] div_frac
);
  logic              lcr_wr;
  logic [DIVI_W-1:0] sh_int;
  logic [DIVF_W-1:0] sh_frac;

  assign lcr_wr = wr_en && addr == 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr      <= '0;
      sh_int   <= '0;
      sh_frac  <= '0;
      div_int  <= '0;
      div_frac <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          lcr      <= lcr_t'(wdata[7:0]);
          div_int  <= sh_int;
          div_frac <= sh_frac;
        end
        2'd1: sh_int  <= wdata[DIVI_W-1:0];
        2'd2: sh_frac <= wdata[DIVF_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata[7:0] = lcr;
      2'd1: rdata[DIVI_W-1:0] = sh_int;
      2'd2: rdata[DIVF_W-1:0] = sh_frac;
      default: ;
    endcase
  end

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> ($stable(div_int) && $stable(div_frac)));
  // R7
  div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr |=> (div_int == $past(sh_int) && div_frac == $past(sh_frac)));
  // R2
  lcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> $stable(lcr));
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         q_en,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cap;
  logic          accept, take;

  assign cap      = q_en ? CW'(DEPTH) : CW'(1);
  assign full     = count >= cap;
  assign empty    = count == '0;
  assign accept   = push && !full;
  assign take     = pop && !empty;
  assign pop_data = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (take)   rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(accept) - CW'(take);
    end
  end

  always_ff @(posedge clk)
    if (accept) mem[wr_ptr] <= push_data;

  // R10
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R9
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> ($stable(count) && $stable(wr_ptr)));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  lcr_t       lcr,
  input  logic       empty,
  input  logic [7:0] byte_in,
  output logic       pop,
  output logic       tx,
  output logic       active
);
  logic [FRAME_MAX-1:0] frame_q;
  logic [3:0]           len_q, idx, tcnt;
  logic                 bit_end, last_bit;

  assign pop      = !active && !empty;
  assign bit_end  = active && tick && tcnt == 4'd15;
  assign last_bit = idx == len_q - 4'd1;
  assign tx       = active ? frame_q[idx] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      frame_q <= '1;
      len_q   <= 4'd1;
      idx     <= '0;
      tcnt    <= '0;
    end else if (pop) begin
      active  <= 1'b1;
      frame_q <= build_frame(byte_in, lcr);
      len_q   <= frame_len(lcr);
      idx     <= '0;
      tcnt    <= '0;
    end else if (active && tick) begin
      tcnt <= tcnt + 4'd1;
      if (bit_end) begin
        if (last_bit) active <= 1'b0;
        else          idx    <= idx + 4'd1;
      end
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !tx);
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> idx < len_q);
  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> (active && $stable(idx)));
  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(len_q) && $stable(frame_q)));
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DIVI_W = 16,
  parameter int DIVF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              push_valid,
  input  logic [7:0]        push_data,
  input  logic              tick16,
  output logic              tx,
  output logic              busy,
  output logic              full,
  output logic [DIVI_W-1:0] div_int,
  output logic [DIVF_W-1:0] div_frac
);
  lcr_t       lcr;
  logic       empty, pop, active;
  logic [7:0] head;

  uart_tx_regs #(.DW(32), .DIVI_W(DIVI_W), .DIVF_W(DIVF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr),
    .wdata(wr_data), .rdata(rd_data), .lcr(lcr),
    .div_int(div_int), .div_frac(div_frac)
  );

  uart_tx_buf #(.DEPTH(DEPTH), .W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .q_en(lcr.q_en), .push(push_valid),
    .push_data(push_data), .pop(pop), .pop_data(head),
    .empty(empty), .full(full)
  );

  uart_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .lcr(lcr), .empty(empty),
    .byte_in(head), .pop(pop), .tx(tx), .active(active)
  );

  assign busy = active || !empty;

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  // R11
  busy_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> busy);
endmodule

// File: tb/uart_tx_framer_bench.sv
module uart_tx_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        push_valid = 1'b0;
  logic [7:0]  push_data = '0;
  logic        tick16 = 1'b0;
  logic        tx, busy, full;
  logic [15:0] div_int;
  logic [5:0]  div_frac;

  int n_chk = 0, n_bad = 0, tick_total = 0, tdiv = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer u_uart_tx_framer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .push_valid(push_valid),
    .push_data(push_data), .tick16(tick16), .tx(tx), .busy(busy),
    .full(full), .div_int(div_int), .div_frac(div_frac)
  );

  // tick every second clock
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 2;
    tick16 = (tdiv == 1);
  end
  always @(posedge clk) if (tick16) tick_total = tick_total + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic push(logic [7:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  function automatic int nbits(logic [7:0] c);
    return 1 + 5 + int'(c[6:5]) + int'(c[1]) + (c[3] ? 2 : 1);
  endfunction

  function automatic logic want(logic [7:0] d, logic [7:0] c, int b);
    int nd; logic p;
    nd = 5 + int'(c[6:5]);
    if (b == 0) return 1'b0;
    if (b <= nd) return d[b-1];
    if (c[1] && b == nd + 1) begin
      if (c[7]) return !c[2];
      p = 1'b0;
      for (int i = 0; i < nd; i++) p = p ^ d[i];
      return c[2] ? p : !p;
    end
    return 1'b1;
  endfunction

  // Receive one frame, checking mid-bit samples; optionally the busy fall
  task automatic rx(string req, logic [7:0] d, logic [7:0] c, bit idle_after);
    int t0, len, guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (tx !== 1'b0 && guard < 4000);
    check({req, " start seen"}, 32'(tx), 32'd0);
    t0 = tick_total;
    len = nbits(c);
    for (int b = 0; b < len; b++) begin
      wait (tick_total >= t0 + 16*b + 8);
      @(negedge clk);
      check($sformatf("%s bit%0d", req, b), 32'(tx), 32'(want(d, c, b)));
    end
    if (idle_after) begin
      wait (tick_total >= t0 + 16*len - 1);
      @(negedge clk);
      check({req, " R11 busy before end"}, 32'(busy), 32'd1);
      wait (tick_total >= t0 + 16*len);
      @(negedge clk);
      check({req, " R11 busy after end"}, 32'(busy), 32'd0);
      check({req, " R11 tx idle"}, 32'(tx), 32'd1);
    end
  endtask

  task automatic t_reset;
    check("R1 tx", 32'(tx), 32'd1);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 full", 32'(full), 32'd0);
    check("R1 div_int", 32'(div_int), 32'd0);
    check("R1 div_frac", 32'(div_frac), 32'd0);
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a); #1;
      check("R1 reg zero", rd_data, 32'd0);
    end
  endtask

  task automatic t_regs;
    wr(2'd0, 32'hABCD_12F1);
    reg_addr = 2'd0; #1;
    check("R2 lcr readback upper zero", rd_data, 32'h0000_00F1);
    wr(2'd0, 32'h0);
    reg_addr = 2'd0; #1;
    check("R2 lcr cleared", rd_data, 32'h0);
  endtask

  task automatic t_shadow;
    wr(2'd1, 32'hFFFF_0123);
    wr(2'd2, 32'hFFFF_FFD5);
    check("R7 int not yet active", 32'(div_int), 32'd0);
    check("R7 frac not yet active", 32'(div_frac), 32'd0);
    reg_addr = 2'd1; #1;
    check("R7 int shadow read", rd_data, 32'h0123);
    reg_addr = 2'd2; #1;
    check("R7 frac shadow read", rd_data, 32'h15);
    wr(2'd0, 32'h0);
    check("R7 int active", 32'(div_int), 32'h0123);
    check("R7 frac active", 32'(div_frac), 32'h15);
  endtask

  task automatic t_frame(string req, logic [7:0] c, logic [7:0] d);
    wr(2'd0, 32'(c));
    fork
      push(d);
      rx(req, d, c, 1'b1);
    join
  endtask

  task automatic t_midframe;
    wr(2'd0, 32'h60);
    fork
      begin push(8'h5A); rx("R8 old fmt", 8'h5A, 8'h60, 1'b0); rx("R8 new fmt", 8'h1F, 8'h00, 1'b1); end
      begin repeat (100) @(negedge clk); wr(2'd0, 32'h00); push(8'h1F); end
    join
  endtask

  task automatic t_char;
    wr(2'd0, 32'h60);
    fork
      begin
        push(8'hC1); repeat (4) @(negedge clk);
        push(8'h3C);
        check("R9 full with one waiting", 32'(full), 32'd1);
        push(8'h99);
        check("R9 full after dropped push", 32'(full), 32'd1);
      end
      begin rx("R9 first", 8'hC1, 8'h60, 1'b0); rx("R9 held", 8'h3C, 8'h60, 1'b1); end
    join
  endtask

  task automatic t_fifo;
    wr(2'd0, 32'h78);
    fork
      begin
        push(8'h00); repeat (4) @(negedge clk);
        for (int i = 1; i <= 16; i++) begin
          check("R10 not full yet", 32'(full), 32'd0);
          push(8'(i * 13));
        end
        check("R10 full at 16", 32'(full), 32'd1);
        push(8'hEE);
        check("R10 full stays", 32'(full), 32'd1);
      end
      begin
        rx("R10 q0", 8'h00, 8'h78, 1'b0);
        for (int i = 1; i <= 16; i++)
          rx($sformatf("R10 R6 q%0d", i), 8'(i * 13), 8'h78, i == 16);
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_regs;
    t_shadow;
    t_frame("R3 5N1", 8'h00, 8'hF5);
    t_frame("R3 8N1", 8'h60, 8'hA5);
    t_frame("R4 8E1", 8'h66, 8'h0B);
    t_frame("R4 7O1", 8'h42, 8'h7F);
    t_frame("R4 6E1", 8'h26, 8'h3E);
    t_frame("R5 stick0", 8'hA6, 8'h3F);
    t_frame("R5 stick1", 8'hE2, 8'h00);
    t_frame("R6 8N2", 8'h68, 8'hC3);
    t_midframe;
    t_char;
    t_fifo;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule